// File: doc/BRIEF.md
# Queued I2C Write Engine

This block lets a host hand off I2C register writes without waiting for the bus. The host fills a small byte-addressed command buffer with a 7-bit target address, a payload count, a register offset and up to ten payload bytes. It then pulses a submit strobe. One cycle later the block returns a status code. Accepted commands go into a four-entry queue. A bit-level master empties the queue in order, issuing each entry as one write transfer on an SCL/SDA pair.

An accepted status only means the command sits in the queue. It says nothing about whether the transfer has run or whether the target acknowledged it. Missing acknowledges are reported separately through a sticky event flag. That flag drives a maskable interrupt line and stays set until the host clears it.

Top module: `i2c_write_queue`

## Requirements
- R1: While reset is held and in the first cycle after it: SCL is high, SDA is released (`sda_oe`=0), `rsp_valid`=0, `nack_flag`=0 and `irq`=0.
- R2: A `cmd_submit` pulse yields `rsp_valid`=1 exactly one cycle later, together with a code: 0 = accepted and queued, 1 = queue full, 2 = bad length.
- R3: Command buffer index 0 holds the target address in bits 6:0, and its bit 7 is ignored. Index 1 is the payload count. Index 2 is reserved and ignored. Index 3 is the register offset. Indices 4..13 are payload bytes 0..9.
- R4: Writes to buffer index 14 or above change nothing that is later sent.
- R5: A payload count above 10 returns code 2 and queues nothing. This check takes priority over the full check. A count of exactly 10 is accepted.
- R6: At most four commands wait in the queue. A submit while four wait returns code 1 and queues nothing. The transfer that is currently on the bus does not hold a queue slot.
- R7: Each queued command appears on the bus as START, then the address byte {addr[6:0],0}, the offset byte and the payload bytes in buffer order, then STOP. Bytes are sent MSB first, and SDA is released for the ninth (acknowledge) clock.
- R8: A NACK on any byte ends that transfer with STOP. No further bytes of that entry are sent, and the next queued entry then runs normally.
- R9: A NACK sets `nack_flag`, which holds until a cycle with `nack_clr`=1. If a new NACK coincides with a clear, the set wins.
- R10: `irq` is the registered AND of `nack_flag` and `nack_irq_en`. It follows either one with one cycle of delay.
- R11: Acceptance does not wait for the bus: code 0 is returned while an earlier transfer is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Write strobe for the command buffer |
| cmd_wr_idx | input | 5 | Buffer byte index |
| cmd_wr_data | input | 8 | Byte to write |
| cmd_submit | input | 1 | Submit the buffer contents as a command |
| rsp_valid | output | 1 | Status code valid (one cycle) |
| rsp_code | output | 2 | 0 accepted, 1 queue full, 2 bad length |
| scl_o | output | 1 | Bus clock, driven push-pull |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA line level |
| nack_clr | input | 1 | Clears the NACK flag |
| nack_irq_en | input | 1 | Interrupt enable for the NACK flag |
| nack_flag | output | 1 | Sticky NACK event |
| irq | output | 1 | Registered interrupt output |

## Verification
The status code is due in the cycle after the edge that samples `cmd_submit`. The bench therefore asserts submit at one falling clock edge and reads `rsp_valid`/`rsp_code` at the next falling edge. Bus bytes arrive hundreds of cycles later, and their timing depends on queue depth. So the bench's target model decodes SCL/SDA once per cycle on falling edges, and a scoreboard compares each byte against the queued expectation in order, whatever the latency. `nack_flag` rises one cycle after the acknowledge slot ends and `irq` one cycle after that. The bench reads both only once the transfers have drained. Mask and clear effects are read one falling edge after the input changes, or two for `irq`.

// File: rtl/i2cwq_pkg.sv
package i2cwq_pkg;
  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_FULL   = 2'd1,
    RSP_BADLEN = 2'd2
  } rsp_e;

  typedef enum logic [2:0] {
    M_IDLE,
    M_FETCH,
    M_START,
    M_BIT,
    M_ACK,
    M_STOP
  } mstate_e;
endpackage

// File: rtl/i2cwq_cmdbuf.sv
module i2cwq_cmdbuf #(
  parameter int MAX_PAY = 10,
  parameter int IDX_W   = 5,
  localparam int NBYTES = 4 + MAX_PAY,
  localparam int AW     = $clog2(NBYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  output logic [6:0]              tgt_addr,
  output logic [7:0]              pay_len,
  output logic [7:0]              reg_off,
  output logic [MAX_PAY-1:0][7:0] payload
);
  logic [7:0] bytes_q [NBYTES];
  logic       unused_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
    end else if (wr_en && (wr_idx < IDX_W'(NBYTES))) begin
      bytes_q[wr_idx[AW-1:0]] <= wr_data;
    end
  end

  assign tgt_addr    = bytes_q[0][6:0];
  assign pay_len     = bytes_q[1];
  assign reg_off     = bytes_q[3];
  assign unused_bits = ^{bytes_q[0][7], bytes_q[2]};

  for (genvar g = 0; g < MAX_PAY; g++) begin : g_pay
    assign payload[g] = bytes_q[4+g];
  end
endmodule

// File: rtl/i2cwq_fifo.sv
module i2cwq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  ram [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) ram[wp] <= din;
    if (do_pop)  dout    <= ram[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2cwq_master.sv
module i2cwq_master
  import i2cwq_pkg::*;
#(
  parameter int MAX_PAY  = 10,
  parameter int QTR_CYC  = 4,
  localparam int LEN_W   = $clog2(MAX_PAY + 1),
  localparam int ENTRY_W = 7 + LEN_W + 8 + 8*MAX_PAY,
  localparam int QW      = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1,
  localparam int BW      = $clog2(MAX_PAY + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               q_avail,
  input  logic [ENTRY_W-1:0] q_data,
  output logic               q_pop,
  input  logic               sda_i,
  output logic               scl_o,
  output logic               sda_oe,
  output logic               nack_evt
);
  mstate_e                 state;
  logic [1:0]              phase;
  logic [QW-1:0]           qcnt;
  logic [2:0]              bit_cnt;
  logic [BW-1:0]           byte_idx;
  logic [7:0]              sh;
  logic                    ack_bad;
  logic [6:0]              w_addr;
  logic [LEN_W-1:0]        w_len;
  logic [7:0]              w_off;
  logic [MAX_PAY-1:0][7:0] w_pay;

  logic          tick, step_done, scl_c, oe_c;
  logic [BW-1:0] last_idx, nidx, pidx;
  logic [7:0]    nxt_byte;

  assign tick      = (qcnt == QW'(QTR_CYC-1));
  assign step_done = tick && (phase == 2'd3);
  assign last_idx  = BW'(w_len) + BW'(1);
  assign nidx      = byte_idx + BW'(1);
  assign pidx      = nidx - BW'(2);
  assign q_pop     = (state == M_IDLE) && q_avail;

  always_comb begin
    nxt_byte = w_off;
    if (nidx != BW'(1)) begin
      for (int i = 0; i < MAX_PAY; i++)
        if (pidx == BW'(i)) nxt_byte = w_pay[i];
    end
  end

  always_comb begin
    scl_c = 1'b1;
    oe_c  = 1'b0;
    case (state)
      M_START: begin scl_c = (phase != 2'd3); oe_c = (phase != 2'd0); end
      M_BIT:   begin scl_c = phase[1];        oe_c = ~sh[7];          end
      M_ACK:   begin scl_c = phase[1];        oe_c = 1'b0;            end
      M_STOP:  begin scl_c = phase[1];        oe_c = (phase != 2'd3); end
      default: begin scl_c = 1'b1;            oe_c = 1'b0;            end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= M_IDLE;
      phase    <= '0;
      qcnt     <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      sh       <= '0;
      ack_bad  <= 1'b0;
      w_addr   <= '0;
      w_len    <= '0;
      w_off    <= '0;
      w_pay    <= '0;
      scl_o    <= 1'b1;
      sda_oe   <= 1'b0;
      nack_evt <= 1'b0;
    end else begin
      scl_o    <= scl_c;
      sda_oe   <= oe_c;
      nack_evt <= 1'b0;
      case (state)
        M_IDLE: if (q_avail) state <= M_FETCH;
        M_FETCH: begin
          w_addr <= q_data[ENTRY_W-1 -: 7];
          w_len  <= q_data[ENTRY_W-8 -: LEN_W];
          w_off  <= q_data[8*MAX_PAY +: 8];
          w_pay  <= q_data[8*MAX_PAY-1:0];
          phase  <= '0;
          qcnt   <= '0;
          state  <= M_START;
        end
        default: begin
          if (tick) begin
            qcnt  <= '0;
            phase <= phase + 2'd1;
          end else begin
            qcnt <= qcnt + QW'(1);
          end
          if ((state == M_ACK) && tick && (phase == 2'd2)) ack_bad <= sda_i;
          if (step_done) begin
            case (state)
              M_START: begin
                sh       <= {w_addr, 1'b0};
                byte_idx <= '0;
                bit_cnt  <= '0;
                state    <= M_BIT;
              end
              M_BIT: begin
                sh <= {sh[6:0], 1'b0};
                if (bit_cnt == 3'd7) begin
                  bit_cnt <= '0;
                  state   <= M_ACK;
                end else begin
                  bit_cnt <= bit_cnt + 3'd1;
                end
              end
              M_ACK: begin
                if (ack_bad) begin
                  nack_evt <= 1'b1;
                  state    <= M_STOP;
                end else if (byte_idx == last_idx) begin
                  state <= M_STOP;
                end else begin
                  byte_idx <= nidx;
                  sh       <= nxt_byte;
                  state    <= M_BIT;
                end
              end
              default: state <= M_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_write_queue.sv
module i2c_write_queue
  import i2cwq_pkg::*;
#(
  parameter int MAX_PAY = 10,
  parameter int Q_DEPTH = 4,
  parameter int QTR_CYC = 4,
  parameter int IDX_W   = 5,
  localparam int LEN_W   = $clog2(MAX_PAY + 1),
  localparam int ENTRY_W = 7 + LEN_W + 8 + 8*MAX_PAY,
  localparam int CW      = $clog2(Q_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr_en,
  input  logic [IDX_W-1:0] cmd_wr_idx,
  input  logic [7:0]       cmd_wr_data,
  input  logic             cmd_submit,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code,
  output logic             scl_o,
  output logic             sda_oe,
  input  logic             sda_i,
  input  logic             nack_clr,
  input  logic             nack_irq_en,
  output logic             nack_flag,
  output logic             irq
);
  logic [6:0]              tgt_addr;
  logic [7:0]              pay_len;
  logic [7:0]              reg_off;
  logic [MAX_PAY-1:0][7:0] payload;
  logic [ENTRY_W-1:0]      entry, q_data;
  logic [CW-1:0]           q_count;
  logic                    len_ok, q_full, push, q_pop, nack_evt;

  i2cwq_cmdbuf #(.MAX_PAY(MAX_PAY), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(cmd_wr_en), .wr_idx(cmd_wr_idx),
    .wr_data(cmd_wr_data), .tgt_addr(tgt_addr), .pay_len(pay_len),
    .reg_off(reg_off), .payload(payload)
  );

  assign len_ok = (pay_len <= 8'(MAX_PAY));
  assign q_full = (q_count == CW'(Q_DEPTH));
  assign push   = cmd_submit && len_ok && !q_full;
  assign entry  = {tgt_addr, pay_len[LEN_W-1:0], reg_off, payload};

  i2cwq_fifo #(.W(ENTRY_W), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(push), .din(entry),
    .pop(q_pop), .dout(q_data), .count(q_count)
  );

  i2cwq_master #(.MAX_PAY(MAX_PAY), .QTR_CYC(QTR_CYC)) u_bus (
    .clk(clk), .rst(rst), .q_avail(q_count != '0), .q_data(q_data),
    .q_pop(q_pop), .sda_i(sda_i), .scl_o(scl_o), .sda_oe(sda_oe),
    .nack_evt(nack_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      nack_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= cmd_submit;
      if (cmd_submit) begin
        if (!len_ok)     rsp_code <= RSP_BADLEN;
        else if (q_full) rsp_code <= RSP_FULL;
        else             rsp_code <= RSP_OK;
      end
      if (nack_evt)      nack_flag <= 1'b1;
      else if (nack_clr) nack_flag <= 1'b0;
      irq <= nack_flag & nack_irq_en;
    end
  end
endmodule

// File: rtl/i2cwq_chk.sv
module i2cwq_chk #(
  parameter int MAX_PAY = 10,
  parameter int Q_DEPTH = 4,
  localparam int CW     = $clog2(Q_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_submit,
  input logic          rsp_valid,
  input logic [1:0]    rsp_code,
  input logic [7:0]    len_byte,
  input logic [CW-1:0] q_count,
  input logic          nack_evt,
  input logic          nack_clr,
  input logic          nack_flag,
  input logic          nack_irq_en,
  input logic          irq
);
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_submit |=> rsp_valid);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_submit |=> !rsp_valid);
  // R5
  len_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_submit && (len_byte > 8'(MAX_PAY))) |=> (rsp_code == 2'd2));
  // R6
  q_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(Q_DEPTH));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nack_flag && !nack_clr) |=> nack_flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (nack_clr && !nack_evt) |=> !nack_flag);
  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !nack_irq_en |=> !irq);
endmodule

bind i2c_write_queue i2cwq_chk #(.MAX_PAY(MAX_PAY), .Q_DEPTH(Q_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_submit(cmd_submit), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .len_byte(pay_len), .q_count(q_count),
  .nack_evt(nack_evt), .nack_clr(nack_clr), .nack_flag(nack_flag),
  .nack_irq_en(nack_irq_en), .irq(irq)
);

// File: tb/i2c_write_queue_test.sv
module i2c_write_queue_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr_en = 1'b0;
  logic [4:0] cmd_wr_idx = '0;
  logic [7:0] cmd_wr_data = '0;
  logic       cmd_submit = 1'b0;
  logic       nack_clr = 1'b0;
  logic       nack_irq_en = 1'b0;
  logic       rsp_valid, scl_o, sda_oe, nack_flag, irq;
  logic [1:0] rsp_code;
  logic       slv_pull = 1'b0;
  logic       sda_line;

  always #2 clk = ~clk;
  assign sda_line = ~(sda_oe | slv_pull);

  i2c_write_queue uut (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_idx(cmd_wr_idx),
    .cmd_wr_data(cmd_wr_data), .cmd_submit(cmd_submit), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_line),
    .nack_clr(nack_clr), .nack_irq_en(nack_irq_en), .nack_flag(nack_flag),
    .irq(irq)
  );

  int         total = 0, bad = 0;
  int         exp_stops = 0, seen_stops = 0;
  int         nack_addr_cfg = -1, nack_byte_cfg = -1;
  string      cur_req = "R7";
  logic [8:0] exp_q [$];
  logic [7:0] shadow [14];
  bit         finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // target model and scoreboard monitor
  logic       pscl = 1'b1, psda = 1'b1, s_c, s_d;
  int         bitn = 0, byte_no = 0;
  logic [7:0] rx = '0;
  logic [8:0] got, want;

  always @(negedge clk) begin
    s_c = scl_o;
    s_d = sda_line;
    if (!rst) begin
      if (pscl && s_c && psda && !s_d) begin
        bitn = 0; byte_no = 0;
      end else if (pscl && s_c && !psda && s_d) begin
        seen_stops++; bitn = 0; slv_pull = 1'b0;
      end else if (!pscl && s_c) begin
        if (bitn < 8) begin
          rx = {rx[6:0], s_d};
          bitn++;
          if (bitn == 8) begin
            got = {(byte_no == 0), rx};
            if (exp_q.size() == 0) begin
              check(1'b0, cur_req, "unexpected byte", int'(got), 0);
            end else begin
              want = exp_q.pop_front();
              check(got == want, cur_req, "bus byte", int'(got), int'(want));
            end
          end
        end
      end else if (pscl && !s_c) begin
        if (bitn == 8) begin
          slv_pull = !((byte_no == 0 && int'(rx[7:1]) == nack_addr_cfg) ||
                       (byte_no == nack_byte_cfg));
          bitn = 9;
          byte_no++;
        end else if (bitn == 9) begin
          slv_pull = 1'b0; bitn = 0;
        end
      end
    end
    pscl = s_c;
    psda = s_d;
  end

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    cmd_wr_en = 1'b1; cmd_wr_idx = 5'(idx); cmd_wr_data = d;
    if (idx < 14) shadow[idx] = d;
    @(negedge clk);
    cmd_wr_en = 1'b0;
  endtask

  // driver: submit, check the code, push the expected bus bytes
  task automatic submit(input int exp_code, input string req);
    logic [7:0] len;
    logic [7:0] b;
    @(negedge clk);
    cmd_submit = 1'b1;
    @(negedge clk);
    cmd_submit = 1'b0;
    check(rsp_valid == 1'b1, req, "rsp_valid", int'(rsp_valid), 1);
    check(int'(rsp_code) == exp_code, req, "rsp_code", int'(rsp_code), exp_code);
    if (exp_code == 0) begin
      len = shadow[1];
      for (int k = 0; k < int'(len) + 2; k++) begin
        b = (k == 0) ? {shadow[0][6:0], 1'b0} : (k == 1) ? shadow[3] : shadow[k+2];
        exp_q.push_back({(k == 0), b});
        if ((k == 0 && int'(shadow[0][6:0]) == nack_addr_cfg) || k == nack_byte_cfg) break;
      end
      exp_stops++;
    end
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, req, "pending bytes", exp_q.size(), 0);
    check(seen_stops == exp_stops, req, "stop count", seen_stops, exp_stops);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", "timeout", 0, 1);
      report();
    end
  end

  initial begin
    for (int i = 0; i < 14; i++) shadow[i] = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(scl_o == 1'b1, "R1", "scl", int'(scl_o), 1);
    check(sda_oe == 1'b0, "R1", "sda_oe", int'(sda_oe), 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    check(nack_flag == 1'b0, "R1", "nack_flag", int'(nack_flag), 0);
    check(irq == 1'b0, "R1", "irq", int'(irq), 0);
    rst = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b1 && sda_oe == 1'b0, "R1", "bus idle after reset",
          int'({scl_o, sda_oe}), 2);

    // R2 R3 R7: reserved bits set, basic write
    cur_req = "R3";
    wr(0, 8'hD2); wr(1, 8'd3); wr(2, 8'hFF); wr(3, 8'h10);
    wr(4, 8'hA1); wr(5, 8'hB2); wr(6, 8'hC3);
    submit(0, "R2");
    drain("R7");

    // R4: out-of-range buffer writes leave the command unchanged
    cur_req = "R4";
    wr(16, 8'h11); wr(14, 8'h22); wr(31, 8'h33); wr(20, 8'h44);
    submit(0, "R4");
    drain("R4");

    // R5: count 11 rejected, count 10 accepted
    cur_req = "R5";
    wr(1, 8'd11);
    submit(2, "R5");
    wr(1, 8'd10);
    for (int i = 0; i < 10; i++) wr(4 + i, 8'(8'h30 + i));
    submit(0, "R5");
    drain("R5");

    // R6 R11: one on the bus, four waiting, sixth refused
    cur_req = "R6";
    wr(1, 8'd2);
    submit(0, "R11");
    for (int i = 0; i < 4; i++) submit(0, "R6");
    submit(1, "R6");
    wr(1, 8'd11);
    submit(2, "R5");
    wr(1, 8'd2);
    drain("R6");

    // R8 R9 R10: address NACK then a good command
    cur_req = "R8";
    nack_irq_en = 1'b1;
    nack_addr_cfg = 7'h33;
    wr(0, 8'h33);
    submit(0, "R8");
    wr(0, 8'h44);
    submit(0, "R8");
    drain("R8");
    check(nack_flag == 1'b1, "R9", "flag after NACK", int'(nack_flag), 1);
    check(irq == 1'b1, "R10", "irq enabled", int'(irq), 1);
    @(negedge clk);
    nack_irq_en = 1'b0;
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10", "irq masked", int'(irq), 0);
    check(nack_flag == 1'b1, "R9", "flag held while masked", int'(nack_flag), 1);
    nack_clr = 1'b1;
    @(negedge clk);
    nack_clr = 1'b0;
    check(nack_flag == 1'b0, "R9", "flag cleared", int'(nack_flag), 0);

    // R8: NACK on the offset byte
    nack_addr_cfg = -1;
    nack_byte_cfg = 1;
    submit(0, "R8");
    drain("R8");
    check(nack_flag == 1'b1, "R9", "flag after data NACK", int'(nack_flag), 1);
    check(irq == 1'b0, "R10", "irq stays masked", int'(irq), 0);

    finished = 1;
    report();
  end
endmodule